// File: doc/BRIEF.md
# Vectored Nested Priority Interrupt Controller

This block gathers 32 interrupt inputs and drives one active-low request line to a processor. Each input has its own configuration word, which sets a 3-bit priority and one of four trigger types, and its own 32-bit vector word. Software turns inputs on or off, and sets or clears their pending state, through command registers where writing a 1 acts on that input and writing a 0 does nothing.

The processor takes an interrupt by reading the acknowledge register. That read returns the vector of the winning input, records the input's number as the current source, and pushes the input's priority level onto an 8-entry nesting stack. While that level is on the stack, only a strictly higher priority can raise the line again. A write to the end-of-interrupt register pops one entry off the stack. If the acknowledge read finds no winner, it returns a programmable spurious vector and pushes a placeholder entry, so that the end-of-interrupt write software issues afterwards leaves the nesting state balanced.

All register access goes over a plain single-cycle 32-bit bus with no back-pressure. Every request is taken in the cycle it is presented, and read data comes back one cycle later, qualified by `bus_rvalid`.

Top module: `vic_ctrl`

## Requirements
- R1: After reset, all inputs are disabled, nothing is pending, the stack is empty, every configuration and vector word reads 0, the status register reads 0 and `irq_n` is high.
- R2: A write to 0x120 enables, and a write to 0x124 disables, each input whose bit is 1. Bits written as 0 leave their input unchanged. The enable mask reads back at 0x110.
- R3: A write to 0x12C sets, and a write to 0x128 clears, the latched pending bit of each input whose bit is 1. A software set re-raises the interrupt. The pending word reads at 0x10C, bit n for input n.
- R4: Configuration bits [6:5] select the trigger type of an input: 00 = level low, 01 = falling edge, 10 = level high, 11 = rising edge. An edge latches the input's pending bit. A level input is pending for as long as its level is active.
- R5: Configuration bits [2:0] hold the priority, and 7 is the highest. Among enabled pending inputs, the highest priority wins. On a tie, the lowest input number wins.
- R6: `irq_n` is low exactly when the winner's priority level is strictly above the top of the nesting stack. An empty stack lies below priority 0.
- R7: A read of 0x100 with a winner returns the winner's vector word (at 0x80 + 4n), makes status 0x108 read n, and pushes the winner's level. It clears the latched pending bit only for edge-type inputs.
- R8: A read of 0x100 with no winner returns the spurious vector word (read/write at 0x134), makes status read 0, and pushes a placeholder at the current level.
- R9: A write to 0x130 pops one stack entry, and status then shows the entry below. A pop on an empty stack has no effect. Eight pops unwind a full stack.
- R10: The stack holds 8 entries. A push onto a full stack is dropped.
- R11: Bit 0 of the core status word at 0x114 reads 1 exactly while `irq_n` is low.
- R12: Read data appears with `bus_rvalid` one cycle after the request. A configuration word keeps only bits [6:5] and [2:0], and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| src_in | input | 32 | Interrupt inputs, bit n = input n |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The state changed by a write, an acknowledge or an input edge is updated at the clock edge that samples it. Because `irq_n` is combinational from that state, it is due in the same cycle. An input edge takes one more edge to register, and read data is due one edge after the request. The bench drives every request on a falling edge, so each request spans exactly one rising edge. It samples `irq_n` and `bus_rdata` on the following falling edge, which is the first point where each of these results is settled. Input edges are driven one falling edge apart, so the edge detector sees both levels before the pending word is read.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    TRG_LVL_LOW  = 2'b00,
    TRG_FALL     = 2'b01,
    TRG_LVL_HIGH = 2'b10,
    TRG_RISE     = 2'b11
  } trig_e;

  localparam int OFS_VEC_BASE = 'h080;
  localparam int OFS_ACK      = 'h100;
  localparam int OFS_FAST     = 'h104;
  localparam int OFS_STATUS   = 'h108;
  localparam int OFS_PEND     = 'h10C;
  localparam int OFS_MASK     = 'h110;
  localparam int OFS_CORE     = 'h114;
  localparam int OFS_EN_SET   = 'h120;
  localparam int OFS_EN_CLR   = 'h124;
  localparam int OFS_PND_CLR  = 'h128;
  localparam int OFS_PND_SET  = 'h12C;
  localparam int OFS_EOI      = 'h130;
  localparam int OFS_SPUR     = 'h134;
endpackage

// File: rtl/vic_src_cell.sv
module vic_src_cell
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src,
  input  logic [1:0] trig,
  input  logic       set_sw,
  input  logic       clr_sw,
  input  logic       ack_clr,
  output logic       pend
);
  logic prev_q, latch_q, edge_hit, level_hit, is_edge;

  assign is_edge   = trig[0];
  assign edge_hit  = (trig == TRG_RISE && src && !prev_q) ||
                     (trig == TRG_FALL && !src && prev_q);
  assign level_hit = (trig == TRG_LVL_HIGH && src) ||
                     (trig == TRG_LVL_LOW && !src);
  assign pend      = latch_q | level_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q <= src;
      if (clr_sw) latch_q <= 1'b0;
      else latch_q <= (latch_q & ~(ack_clr & is_edge)) | set_sw | edge_hit;
    end
  end

  // software set makes the input pending on the next cycle (R3)
  assert_sw_set_pends_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (set_sw && !clr_sw) |=> pend);
  // an acknowledge of an edge input with no new event leaves it idle (R7)
  assert_edge_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_clr && is_edge && !set_sw && !edge_hit && !clr_sw && $stable(trig)) |=> !latch_q);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  localparam int ID_W  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        cand,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic                   found,
  output logic [ID_W-1:0]        win_id,
  output logic [PRIO_W-1:0]      win_prio
);
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '0;
    for (int n = 0; n < NSRC; n++) begin
      if (cand[n] && (!found || prio_flat[n*PRIO_W +: PRIO_W] > win_prio)) begin
        found    = 1'b1;
        win_id   = ID_W'(n);
        win_prio = prio_flat[n*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/vic_nest_stack.sv
module vic_nest_stack #(
  parameter int DEPTH = 8,
  parameter int LVL_W = 4,
  parameter int ID_W  = 5,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic [ID_W-1:0]  push_id,
  input  logic             pop,
  output logic [LVL_W-1:0] top_lvl,
  output logic [ID_W-1:0]  top_id,
  output logic             full
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [LVL_W-1:0] lvl_q [DEPTH];
  logic [ID_W-1:0]  id_q  [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] wr_idx, top_idx;
  logic             empty;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign wr_idx  = IDX_W'(cnt_q);
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign top_lvl = empty ? '0 : lvl_q[top_idx];
  assign top_id  = empty ? '0 : id_q[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        lvl_q[i] <= '0;
        id_q[i]  <= '0;
      end
    end else if (push && !full) begin
      lvl_q[wr_idx] <= push_lvl;
      id_q[wr_idx]  <= push_id;
      cnt_q         <= cnt_q + CNT_W'(1);
    end else if (pop && !empty) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assert_pop_empty_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty);
  assert_full_push_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (full && $stable(top_lvl)));
  assert_push_lands_on_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> (top_lvl == $past(push_lvl) && top_id == $past(push_id)));
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 3,
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 9,
  localparam int ID_W  = $clog2(NSRC),
  localparam int LVL_W = PRIO_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  input  logic [NSRC-1:0]   src_in,
  output logic              irq_n
);
  logic [1:0]        trig_q [NSRC];
  logic [PRIO_W-1:0] prio_q [NSRC];
  logic [31:0]       vec_q  [NSRC];
  logic [NSRC-1:0]   en_q, pend, cand, set_v, clr_v, ack_v;
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [31:0]       spur_q, rd_mux;

  logic              rd, wr, ack, eoi, word_ok, idx_ok, in_mode, in_vec;
  logic [ID_W-1:0]   idx;
  logic              found, irq_req, stk_full;
  logic [ID_W-1:0]   win_id, top_id;
  logic [PRIO_W-1:0] win_prio;
  logic [LVL_W-1:0]  win_lvl, top_lvl;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // bus decode
  assign rd      = bus_sel && !bus_wr;
  assign wr      = bus_sel && bus_wr;
  assign idx     = bus_addr[ID_W+1:2];
  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign idx_ok  = (ID_W + 1)'(idx) < (ID_W + 1)'(NSRC);
  assign in_mode = word_ok && idx_ok && (bus_addr[ADDR_W-1:7] == '0);
  assign in_vec  = word_ok && idx_ok &&
                   (bus_addr[ADDR_W-1:7] == (ADDR_W - 7)'(OFS_VEC_BASE >> 7));
  assign ack     = rd && hit(bus_addr, OFS_ACK);
  assign eoi     = wr && hit(bus_addr, OFS_EOI);
  assign set_v   = (wr && hit(bus_addr, OFS_PND_SET)) ? bus_wdata[NSRC-1:0] : '0;
  assign clr_v   = (wr && hit(bus_addr, OFS_PND_CLR)) ? bus_wdata[NSRC-1:0] : '0;

  // per-input configuration and pending logic
  for (genvar n = 0; n < NSRC; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        trig_q[n] <= 2'b00;
        prio_q[n] <= '0;
        vec_q[n]  <= '0;
      end else if (wr && idx == ID_W'(n)) begin
        if (in_mode) begin
          trig_q[n] <= bus_wdata[6:5];
          prio_q[n] <= bus_wdata[PRIO_W-1:0];
        end
        if (in_vec) vec_q[n] <= bus_wdata;
      end
    end

    assign prio_flat[n*PRIO_W +: PRIO_W] = prio_q[n];
    assign ack_v[n] = ack && irq_req && (win_id == ID_W'(n));

    vic_src_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (src_in[n]),
      .trig    (trig_q[n]),
      .set_sw  (set_v[n]),
      .clr_sw  (clr_v[n]),
      .ack_clr (ack_v[n]),
      .pend    (pend[n])
    );
  end

  // enable mask and spurious vector
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      spur_q <= '0;
    end else if (wr) begin
      if (hit(bus_addr, OFS_EN_SET)) en_q <= en_q | bus_wdata[NSRC-1:0];
      if (hit(bus_addr, OFS_EN_CLR)) en_q <= en_q & ~bus_wdata[NSRC-1:0];
      if (hit(bus_addr, OFS_SPUR))   spur_q <= bus_wdata;
    end
  end

  // arbitration and nesting
  assign cand = pend & en_q;

  vic_arbiter #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_arb (
    .cand      (cand),
    .prio_flat (prio_flat),
    .found     (found),
    .win_id    (win_id),
    .win_prio  (win_prio)
  );

  assign win_lvl = LVL_W'(win_prio) + LVL_W'(1);
  assign irq_req = found && (win_lvl > top_lvl);
  assign irq_n   = !irq_req;

  vic_nest_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W), .ID_W(ID_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (ack),
    .push_lvl (irq_req ? win_lvl : top_lvl),
    .push_id  (irq_req ? win_id : '0),
    .pop      (eoi),
    .top_lvl  (top_lvl),
    .top_id   (top_id),
    .full     (stk_full)
  );

  // read path
  always_comb begin
    rd_mux = '0;
    if (in_mode) begin
      rd_mux[6:5]        = trig_q[idx];
      rd_mux[PRIO_W-1:0] = prio_q[idx];
    end else if (in_vec) begin
      rd_mux = vec_q[idx];
    end else if (hit(bus_addr, OFS_ACK)) begin
      rd_mux = irq_req ? vec_q[win_id] : spur_q;
    end else if (hit(bus_addr, OFS_STATUS)) begin
      rd_mux[ID_W-1:0] = top_id;
    end else if (hit(bus_addr, OFS_PEND)) begin
      rd_mux[NSRC-1:0] = pend;
    end else if (hit(bus_addr, OFS_MASK)) begin
      rd_mux[NSRC-1:0] = en_q;
    end else if (hit(bus_addr, OFS_CORE)) begin
      rd_mux[0] = irq_req;
    end else if (hit(bus_addr, OFS_SPUR)) begin
      rd_mux = spur_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= rd;
      bus_rdata  <= rd ? rd_mux : '0;
    end
  end

  assert_irq_needs_candidate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> |(pend & en_q));
  assert_winner_is_candidate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> cand[win_id]);
  assert_spurious_status_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !irq_req && !stk_full) |=> (top_id == '0));
  assert_ack_raises_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !stk_full) |=> (top_lvl > $past(top_lvl)));
  assert_rvalid_follows_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> bus_rvalid);
endmodule

// File: tb/test_vic_ctrl.sv
module test_vic_ctrl;
  localparam logic [8:0] A_ACK = 9'h100, A_STAT = 9'h108, A_PEND = 9'h10C,
                         A_MASK = 9'h110, A_CORE = 9'h114, A_ENS = 9'h120,
                         A_ENC = 9'h124, A_PCLR = 9'h128, A_PSET = 9'h12C,
                         A_EOI = 9'h130, A_SPUR = 9'h134;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [8:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        bus_rvalid, irq_n;
  logic [31:0] src_in = '1;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vic_ctrl i_vic_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_in(src_in), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr32(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd32(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
    checks++;
    if (bus_rvalid !== 1'b1) begin
      errors++;
      $display("FAIL R12 rvalid actual=%b expected=1", bus_rvalid);
    end
  endtask

  task automatic expect_rd(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd32(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    check("R1 irq_n", {31'b0, irq_n}, 32'h1);
    expect_rd("R1 pending", A_PEND, 32'h0);
    expect_rd("R1 mask", A_MASK, 32'h0);
    expect_rd("R1 status", A_STAT, 32'h0);
    expect_rd("R1 mode3", 9'h00C, 32'h0);
    expect_rd("R1 vector5", 9'h094, 32'h0);
  endtask

  task automatic t_enable();
    wr32(A_ENS, 32'h0000_00F0);
    expect_rd("R2 enable set", A_MASK, 32'h0000_00F0);
    wr32(A_ENC, 32'h0000_0030);
    expect_rd("R2 disable", A_MASK, 32'h0000_00C0);
    wr32(A_ENS, 32'h0);
    expect_rd("R2 zero write no effect", A_MASK, 32'h0000_00C0);
    wr32(A_ENC, 32'hFFFF_FFFF);
    expect_rd("R2 disable all", A_MASK, 32'h0);
  endtask

  task automatic t_pending_and_modes();
    wr32(A_PSET, 32'h0000_0008);
    expect_rd("R3 set pending", A_PEND, 32'h0000_0008);
    wr32(A_PCLR, 32'h0000_0008);
    expect_rd("R3 clear pending", A_PEND, 32'h0);
    wr32(9'h014, 32'hFFFF_FFFF);
    expect_rd("R12 mode keeps only type and priority", 9'h014, 32'h0000_0067);
    wr32(9'h014, 32'h0);
    wr32(9'h030, 32'h0000_0041);
    expect_rd("R4 level high active", A_PEND, 32'h0000_1000);
    @(negedge clk); src_in[12] = 1'b0;
    expect_rd("R4 level high released", A_PEND, 32'h0);
    wr32(9'h034, 32'h0000_0021);
    @(negedge clk); src_in[13] = 1'b0;
    @(negedge clk); src_in[13] = 1'b1;
    expect_rd("R4 falling edge latched", A_PEND, 32'h0000_2000);
    wr32(A_PCLR, 32'h0000_2000);
    expect_rd("R4 latched edge cleared", A_PEND, 32'h0);
    wr32(9'h030, 32'h0);
    @(negedge clk); src_in[12] = 1'b1;
    wr32(9'h034, 32'h0);
  endtask

  task automatic t_nesting();
    wr32(9'h008, 32'h06); wr32(9'h024, 32'h06); wr32(9'h010, 32'h03);
    wr32(9'h050, 32'h67);
    for (int n = 0; n < 32; n++) wr32(9'h080 + 9'(4 * n), 32'h100 + n);
    wr32(A_SPUR, 32'h0000_ABCD);
    wr32(A_ENS, 32'h0010_0214);
    wr32(A_PSET, 32'h0000_0214);
    check("R6 irq raised", {31'b0, irq_n}, 32'h0);
    expect_rd("R5 tie lowest number wins", A_ACK, 32'h102);
    expect_rd("R7 status source", A_STAT, 32'd2);
    check("R6 equal priority blocked", {31'b0, irq_n}, 32'h1);
    expect_rd("R7 level input stays pending", A_PEND, 32'h0000_0214);
    @(negedge clk); src_in[20] = 1'b0;
    @(negedge clk); src_in[20] = 1'b1;
    @(negedge clk);
    check("R6 higher priority nests", {31'b0, irq_n}, 32'h0);
    expect_rd("R7 nested vector", A_ACK, 32'h114);
    expect_rd("R7 edge pending cleared", A_PEND, 32'h0000_0214);
    expect_rd("R7 nested status", A_STAT, 32'd20);
    expect_rd("R8 spurious vector", A_ACK, 32'h0000_ABCD);
    expect_rd("R8 spurious status", A_STAT, 32'd0);
    expect_rd("R11 core status idle", A_CORE, 32'h0);
    wr32(A_EOI, 32'h0);
    expect_rd("R9 pop placeholder", A_STAT, 32'd20);
    wr32(A_EOI, 32'h0);
    expect_rd("R9 pop to outer", A_STAT, 32'd2);
    check("R6 outer level still blocks", {31'b0, irq_n}, 32'h1);
    wr32(A_EOI, 32'h0);
    check("R9 unwound raises irq", {31'b0, irq_n}, 32'h0);
    expect_rd("R11 core status active", A_CORE, 32'h1);
    expect_rd("R7 re-acknowledge", A_ACK, 32'h102);
    wr32(A_PCLR, 32'hFFFF_FFFF);
    wr32(A_EOI, 32'h0);
    wr32(A_ENC, 32'hFFFF_FFFF);
    check("R3 cleared all", {31'b0, irq_n}, 32'h1);
  endtask

  task automatic t_depth();
    for (int k = 0; k < 8; k++) wr32(9'(4 * k), 32'h60 + k);
    wr32(A_ENS, 32'h0000_00FF);
    for (int k = 0; k < 8; k++) begin
      wr32(A_PSET, 32'h1 << k);
      expect_rd("R10 nested acknowledge", A_ACK, 32'h100 + k);
    end
    check("R10 full stack blocks", {31'b0, irq_n}, 32'h1);
    expect_rd("R10 status at depth 8", A_STAT, 32'd7);
    expect_rd("R10 spurious when full", A_ACK, 32'h0000_ABCD);
    wr32(A_PSET, 32'h1);
    for (int k = 0; k < 7; k++) wr32(A_EOI, 32'h0);
    check("R9 seven pops leave level 0", {31'b0, irq_n}, 32'h1);
    wr32(A_EOI, 32'h0);
    check("R9 eighth pop unwinds", {31'b0, irq_n}, 32'h0);
    expect_rd("R9 status empty", A_STAT, 32'd0);
    wr32(A_EOI, 32'h0);
    check("R9 pop on empty", {31'b0, irq_n}, 32'h0);
    expect_rd("R9 status still empty", A_STAT, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enable();
    t_pending_and_modes();
    t_nesting();
    t_depth();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule